// File: doc/BRIEF.md
# 1-Wire Bit Slot Engine

This block is a bus-master engine that produces exactly one 1-Wire time slot per command on an open-drain line. It can produce three kinds of slot: a write of a one, a write of a zero, or a read. A command carries the slot kind and a speed select, regular or overdrive. The engine pulls the line low for a kind- and speed-dependent time and then releases it. For a read, it samples the line at a fixed point. It then waits out a recovery interval and ends with a one-cycle done strobe.

The line is seen as two signals: a drive-low enable going out, and a sampled input that reflects the external pull-up together with any slave pulling low. The input passes through a two-flop synchroniser. All timing is counted in microseconds. A prescaler derives the microsecond tick from the clock, and `CLK_PER_US` gives the number of clock cycles per microsecond. The prescaler restarts on every accepted command, so each interval lasts an exact number of clock cycles.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_bit` and `ow_drive_low` are all 0.
- R2: When `cmd_valid` is high and `busy` is low, the command is accepted at that clock edge. `busy` is then high from the next cycle up to the last cycle before `done`, which is (slot + recovery) x `CLK_PER_US` cycles.
- R3: While `busy` is high, `cmd_valid` is ignored: the running slot's drive and end timing are unchanged and no extra slot starts.
- R4: With `cmd_read`=0 and `cmd_bit`=1, the line is driven low for one contiguous pulse of 6 us at regular speed (`cmd_od`=0), or 1 us at overdrive (`cmd_od`=1), starting the cycle after acceptance.
- R5: With `cmd_read`=0 and `cmd_bit`=0, the low pulse lasts 60 us at regular speed, or 7 us at overdrive.
- R6: With `cmd_read`=1, the low pulse lasts 6 us at regular speed, or 1 us at overdrive. `cmd_bit` is not used.
- R7: `done` rises 72 us after acceptance at regular speed (70 us slot + 2 us recovery), or 12 us after acceptance at overdrive (10 us slot + 2 us recovery). The line is released whenever `done` is high.
- R8: `done` is a single-cycle pulse, and `busy` is low in the cycle where `done` is high.
- R9: A read returns the synchronised line level taken at 14 us (regular) or 2 us (overdrive) after acceptance. A low level gives 0 and a high level gives 1. A slave that releases the line a few cycles before that point reads as 1. A slave that holds the line past that point reads as 0.
- R10: `rd_bit` changes only in the `done` cycle of a read slot. Write slots leave it unchanged.
- R11: A command presented in the `done` cycle is accepted at once. The new slot drives low in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Slot request, taken when not busy |
| cmd_read | input | 1 | 1 = read slot, 0 = write slot |
| cmd_bit | input | 1 | Bit value for a write slot |
| cmd_od | input | 1 | 1 = overdrive timing, 0 = regular timing |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle strobe at end of recovery |
| rd_bit | output | 1 | Bit sampled by the last read slot |
| ow_drive_low | output | 1 | Open-drain pull-down enable |
| ow_line_in | input | 1 | Observed line level |

## Verification
Two events can fall in the same cycle: the end of one slot (the `done` strobe with `busy` falling) and the acceptance of the next command. The bench provokes this by raising `cmd_valid` in the very cycle `done` is seen. It then checks that `busy` and the drive are high in the following cycle and that the new slot's low time and length are exact. A second overlap is a stray command arriving mid-slot. This is judged by comparing the running slot's measured pulse and end cycle against the values the command would have produced alone.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } slot_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ow_sync2.sv
module ow_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {2{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[1];
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
    import ow_slot_pkg::*;
#(
    parameter int US_W          = 7,
    parameter int REG_W1_LOW_US = 6,
    parameter int REG_W0_LOW_US = 60,
    parameter int REG_RD_LOW_US = 6,
    parameter int REG_SMP_US    = 14,
    parameter int REG_SLOT_US   = 70,
    parameter int OD_W1_LOW_US  = 1,
    parameter int OD_W0_LOW_US  = 7,
    parameter int OD_RD_LOW_US  = 1,
    parameter int OD_SMP_US     = 2,
    parameter int OD_SLOT_US    = 10,
    parameter int REC_US        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_read,
    input  logic cmd_bit,
    input  logic cmd_od,
    input  logic tick,
    input  logic line_s,
    output logic presc_clr,
    output logic busy,
    output logic done,
    output logic rd_bit,
    output logic drive_low
);
    localparam logic [US_W-1:0] K_REG_W1  = US_W'(REG_W1_LOW_US);
    localparam logic [US_W-1:0] K_REG_W0  = US_W'(REG_W0_LOW_US);
    localparam logic [US_W-1:0] K_REG_RD  = US_W'(REG_RD_LOW_US);
    localparam logic [US_W-1:0] K_REG_SMP = US_W'(REG_SMP_US);
    localparam logic [US_W-1:0] K_REG_END = US_W'(REG_SLOT_US + REC_US);
    localparam logic [US_W-1:0] K_OD_W1   = US_W'(OD_W1_LOW_US);
    localparam logic [US_W-1:0] K_OD_W0   = US_W'(OD_W0_LOW_US);
    localparam logic [US_W-1:0] K_OD_RD   = US_W'(OD_RD_LOW_US);
    localparam logic [US_W-1:0] K_OD_SMP  = US_W'(OD_SMP_US);
    localparam logic [US_W-1:0] K_OD_END  = US_W'(OD_SLOT_US + REC_US);

    typedef struct packed {
        slot_st_e        st;
        logic [US_W-1:0] us;
        logic [US_W-1:0] low_us;
        logic [US_W-1:0] smp_us;
        logic [US_W-1:0] end_us;
        logic            is_rd;
        logic            smp;
        logic            drv;
        logic            done;
        logic            rbit;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [US_W-1:0] us_inc;

    assign us_inc = ctl_q.us + 1'b1;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.st     = ST_RUN;
                    ctl_d.us     = '0;
                    ctl_d.drv    = 1'b1;
                    ctl_d.is_rd  = cmd_read;
                    ctl_d.smp    = 1'b1;
                    if (cmd_od) begin
                        ctl_d.low_us = cmd_read ? K_OD_RD : (cmd_bit ? K_OD_W1 : K_OD_W0);
                        ctl_d.smp_us = K_OD_SMP;
                        ctl_d.end_us = K_OD_END;
                    end else begin
                        ctl_d.low_us = cmd_read ? K_REG_RD : (cmd_bit ? K_REG_W1 : K_REG_W0);
                        ctl_d.smp_us = K_REG_SMP;
                        ctl_d.end_us = K_REG_END;
                    end
                end
            end
            ST_RUN: begin
                if (tick) begin
                    ctl_d.us = us_inc;
                    if (us_inc == ctl_q.low_us) begin
                        ctl_d.drv = 1'b0;
                    end
                    if (ctl_q.is_rd && (us_inc == ctl_q.smp_us)) begin
                        ctl_d.smp = line_s;
                    end
                    if (us_inc == ctl_q.end_us) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.drv  = 1'b0;
                        if (ctl_q.is_rd) begin
                            ctl_d.rbit = ctl_q.smp;
                        end
                    end
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, us: '0, low_us: '0, smp_us: '0, end_us: '0,
                       is_rd: 1'b0, smp: 1'b1, drv: 1'b0, done: 1'b0, rbit: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign presc_clr = (ctl_q.st == ST_IDLE);
    assign busy      = (ctl_q.st == ST_RUN);
    assign done      = ctl_q.done;
    assign rd_bit    = ctl_q.rbit;
    assign drive_low = ctl_q.drv;
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import ow_slot_pkg::*;
#(
    parameter int CLK_PER_US    = 125,
    parameter int REG_W1_LOW_US = 6,
    parameter int REG_W0_LOW_US = 60,
    parameter int REG_RD_LOW_US = 6,
    parameter int REG_SMP_US    = 14,
    parameter int REG_SLOT_US   = 70,
    parameter int OD_W1_LOW_US  = 1,
    parameter int OD_W0_LOW_US  = 7,
    parameter int OD_RD_LOW_US  = 1,
    parameter int OD_SMP_US     = 2,
    parameter int OD_SLOT_US    = 10,
    parameter int REC_US        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_read,
    input  logic cmd_bit,
    input  logic cmd_od,
    output logic busy,
    output logic done,
    output logic rd_bit,
    output logic ow_drive_low,
    input  logic ow_line_in
);
    localparam int MAX_END_US = max2(REG_SLOT_US, OD_SLOT_US) + REC_US;
    localparam int US_W       = $clog2(MAX_END_US + 1);

    logic tick;
    logic presc_clr;
    logic line_s;

    ow_us_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .tick  (tick)
    );

    ow_sync2 #(.RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ow_line_in),
        .dout  (line_s)
    );

    ow_slot_ctrl #(
        .US_W          (US_W),
        .REG_W1_LOW_US (REG_W1_LOW_US),
        .REG_W0_LOW_US (REG_W0_LOW_US),
        .REG_RD_LOW_US (REG_RD_LOW_US),
        .REG_SMP_US    (REG_SMP_US),
        .REG_SLOT_US   (REG_SLOT_US),
        .OD_W1_LOW_US  (OD_W1_LOW_US),
        .OD_W0_LOW_US  (OD_W0_LOW_US),
        .OD_RD_LOW_US  (OD_RD_LOW_US),
        .OD_SMP_US     (OD_SMP_US),
        .OD_SLOT_US    (OD_SLOT_US),
        .REC_US        (REC_US)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_bit   (cmd_bit),
        .cmd_od    (cmd_od),
        .tick      (tick),
        .line_s    (line_s),
        .presc_clr (presc_clr),
        .busy      (busy),
        .done      (done),
        .rd_bit    (rd_bit),
        .drive_low (ow_drive_low)
    );
endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic rd_bit,
    input logic ow_drive_low
);
    // R1 / R7: line is never pulled while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ow_drive_low);

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && ow_drive_low));

    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r7_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ow_drive_low);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_rdbit_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> done);
endmodule

bind ow_slot_engine ow_slot_engine_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .done         (done),
    .rd_bit       (rd_bit),
    .ow_drive_low (ow_drive_low)
);

// File: tb/test_ow_slot_engine.sv
module test_ow_slot_engine;
    localparam int P = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cmd_valid, cmd_read, cmd_bit, cmd_od, slave_low;
    logic busy, done, rd_bit, drv;
    logic line;
    assign line = !(drv || slave_low);

    int checks = 0;
    int errors = 0;
    logic exp_rbit = 1'b0;
    bit preissued = 1'b0;
    bit prev_b2b = 1'b0;

    ow_slot_engine #(.CLK_PER_US(P)) i_ow_slot_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_read     (cmd_read),
        .cmd_bit      (cmd_bit),
        .cmd_od       (cmd_od),
        .busy         (busy),
        .done         (done),
        .rd_bit       (rd_bit),
        .ow_drive_low (drv),
        .ow_line_in   (line)
    );

    function automatic int low_us(bit rd, bit b, bit od);
        if (od) return rd ? 1 : (b ? 1 : 7);
        return rd ? 6 : (b ? 6 : 60);
    endfunction

    function automatic int smp_us(bit od);
        return od ? 2 : 14;
    endfunction

    function automatic int total_us(bit od);
        return od ? 12 : 72;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // smode: 0 no slave pull, 1 slave releases before sample point, 2 slave holds past it
    task automatic run_slot(bit rd, bit b, bit od, int smode, bit inject,
                            bit b2b, bit nrd, bit nb, bit nod);
        int l_cyc, t_cyc, s_cyc, rel, drv_cnt, busy_cnt, done_k, rises;
        bit pull, prev, exp_b;
        string kind;
        l_cyc = low_us(rd, b, od) * P;
        t_cyc = total_us(od) * P;
        s_cyc = smp_us(od) * P;
        pull  = rd && (smode != 0);
        rel   = (smode == 1) ? s_cyc - 6 : s_cyc + 3;
        exp_b = !(rd && smode == 2);
        kind  = rd ? "R6 read low" : (b ? "R4 write-one low" : "R5 write-zero low");
        if (!preissued) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_read = rd; cmd_bit = b; cmd_od = od;
        end
        preissued = 1'b0;
        @(posedge clk);
        drv_cnt = 0; busy_cnt = 0; done_k = -1; rises = 0; prev = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk(busy == 1'b1, "R2 busy after accept", busy, 1);
                chk(done == 1'b0, "R8 done dropped", done, 0);
                if (prev_b2b) chk(busy && drv, "R11 back-to-back start", drv, 1);
                cmd_valid = 1'b0;
            end
            if (inject && k == 5) begin
                cmd_valid = 1'b1; cmd_read = !rd; cmd_bit = !b; cmd_od = !od;
            end
            if (inject && k == 6) cmd_valid = 1'b0;
            slave_low = pull && (k < rel);
            if (drv && !prev) rises++;
            prev = drv;
            drv_cnt += int'(drv);
            busy_cnt += int'(busy);
            if (done) begin
                done_k = k;
                break;
            end
        end
        slave_low = 1'b0;
        chk(drv_cnt == l_cyc, kind, drv_cnt, l_cyc);
        chk(rises == 0, {kind, " contiguous"}, rises, 0);
        chk(done_k == t_cyc, "R7 slot end", done_k, t_cyc);
        chk(busy_cnt == t_cyc, "R2 busy span", busy_cnt, t_cyc);
        chk(busy == 1'b0 && drv == 1'b0, "R8 R7 idle at done", {busy, drv}, 0);
        if (inject) chk(drv_cnt == l_cyc && done_k == t_cyc, "R3 ignored while busy", done_k, t_cyc);
        if (rd) begin
            exp_rbit = exp_b;
            chk(rd_bit == exp_rbit, "R9 read sample", rd_bit, exp_rbit);
        end else begin
            chk(rd_bit == exp_rbit, "R10 write keeps rd_bit", rd_bit, exp_rbit);
        end
        prev_b2b = b2b;
        if (b2b) begin
            cmd_valid = 1'b1; cmd_read = nrd; cmd_bit = nb; cmd_od = nod;
            preissued = 1'b1;
        end else begin
            @(negedge clk);
            chk(done == 1'b0, "R8 single pulse", done, 0);
            chk(busy == 1'b0, "R3 no extra slot", busy, 0);
        end
    endtask

    initial begin
        int unsigned seed_v;
        bit crd, cb, cod, nrd, nb, nod, b2b;
        int sm, nsm;
        seed_v = $urandom(32'd1307);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_bit = 1'b0;
        cmd_od = 1'b0; slave_low = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !rd_bit && !drv, "R1 reset state", {busy, done, rd_bit, drv}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_slot(0, 1, 0, 0, 0, 0, 0, 0, 0);   // R4 regular
        run_slot(0, 0, 0, 0, 0, 0, 0, 0, 0);   // R5 regular
        run_slot(1, 0, 0, 2, 0, 0, 0, 0, 0);   // R9 slave 0
        run_slot(0, 1, 1, 0, 0, 0, 0, 0, 0);   // R10 write keeps 0
        run_slot(1, 1, 0, 1, 0, 0, 0, 0, 0);   // R9 early release -> 1
        run_slot(0, 0, 1, 0, 0, 0, 0, 0, 0);   // R5 overdrive
        run_slot(1, 0, 1, 2, 0, 0, 0, 0, 0);   // R9 overdrive 0
        run_slot(1, 0, 1, 1, 1, 0, 0, 0, 0);   // R3 inject, overdrive early release
        run_slot(0, 0, 0, 0, 1, 1, 1, 0, 1);   // R11 chain into overdrive read
        run_slot(1, 0, 1, 0, 0, 1, 0, 1, 0);   // R11 chain into regular write-one
        run_slot(0, 1, 0, 0, 0, 0, 0, 0, 0);

        crd = 1'($urandom % 2); cb = 1'($urandom % 2); cod = 1'($urandom % 2);
        sm = int'($urandom % 3);
        for (int i = 0; i < 30; i++) begin
            nrd = 1'($urandom % 2); nb = 1'($urandom % 2); nod = 1'($urandom % 2);
            nsm = int'($urandom % 3);
            b2b = (i != 29) && ($urandom % 3 == 0);
            run_slot(crd, cb, cod, sm, ($urandom % 4 == 0), b2b, nrd, nb, nod);
            if (!b2b) repeat (int'($urandom % 4)) @(negedge clk);
            crd = nrd; cb = nb; cod = nod; sm = nsm;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule